// File: doc/BRIEF.md
# Three-Channel Half-Bridge Drive Controller

This block turns a committed 16-bit control word, one shared PWM pin and a set of fault indications into the gate enables for three half-bridges. Each half-bridge has a low-side switch and a high-side switch. The block also assembles a 16-bit status word that the serial front end shifts back to the host. The serial interface and the analog sensing sit outside this block. The block receives the control word in parallel, together with a one-cycle commit strobe. It receives undervoltage, overcurrent, overtemperature, prewarning and open-load indications as synchronous flags.

Switch index order, used everywhere: 0 = low side of bridge 1, 1 = high side of bridge 1, 2 = low side of bridge 2, 3 = high side of bridge 2, 4 = low side of bridge 3, 5 = high side of bridge 3.

Control word fields:

| Bits | Meaning |
|---|---|
| 0 | Status reset (clear) |
| 1 to 6 | Switch enables, in switch index order |
| 7 to 12 | PWM-select bits, in the same order |
| 13 | Open-load detection off (high = off) |
| 14 | Overcurrent shutdown enable (high = enabled) |
| 15 | Run (low = standby) |

Status word fields:

| Bits | Meaning |
|---|---|
| 0 | Thermal prewarning |
| 1 to 6 | Per-switch state |
| 7 to 12 | Always zero |
| 13 | Overload |
| 14 | Inhibit |
| 15 | Supply fail |

Faults latch, and the outputs they disabled stay off, until the host writes a word with the clear bit set. Undervoltage is the one exception: the outputs return by themselves when the supply recovers, while the supply-fail bit stays latched.

Top module: `hb_drive_ctrl`

## Requirements
- R1: The control word is captured on the clock edge where `ctrl_commit` is high. Switch i is driven when control bit i+1 is set. If its PWM-select bit (bit i+7) is also set, switch i is driven only while `pwm_in` is high. `pwm_in` alone never drives a switch. A gate follows `pwm_in` one clock later.
- R2: When both enable bits of one half-bridge are set, both of its gates stay low. The gates of the other bridges are unaffected.
- R3: After one gate of a pair falls, the opposite gate of that pair rises no earlier than DEAD_CYC+1 clock edges later. A gate that is turning on again on the same side does not wait.
- R4: With control bit 15 low, all six gates are low, and status bit 14 reads high. Status bit 14 is always the inverse of control bit 15.
- R5: When `uv_flag` is high for UV_DLY consecutive clock edges, status bit 15 sets and all gates go low. Shorter pulses have no effect. When the flag drops, the gates resume without any write, and bit 15 stays set.
- R6: With control bit 14 high, `oc_flag[i]` held for OC_DLY consecutive edges latches switch i off and sets status bit 13. With bit 14 low, overcurrent neither turns a switch off nor sets bit 13.
- R7: `ot_flag[i]` turns off switch i only, and sets status bit 13. Switch i comes back only after `ot_flag[i]` is low and a write with bit 0 set has been committed.
- R8: A committed write with bit 0 set clears status bits 15 and 13 and the overcurrent latches. A fault still present in the same cycle sets its bit again.
- R9: With control bit 13 low, status bit i+1 of a switch whose gate is low reports `openload_flag[i]`. In every other case it reports the gate state. The clear bit does not alter it.
- R10: Status bit 0 equals `prewarn_flag` without latching, and status bits 7 to 12 read zero.
- R11: After reset, the control word is 16'hE000, every gate is low, and no fault bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Control word from the serial front end |
| ctrl_commit | input | 1 | One-cycle strobe that captures `ctrl_word` |
| pwm_in | input | 1 | Shared PWM input, synchronous |
| uv_flag | input | 1 | Supply undervoltage comparator |
| oc_flag | input | 6 | Per-switch overcurrent comparators |
| ot_flag | input | 6 | Per-switch over-shutdown-temperature flags, with hysteresis applied upstream |
| prewarn_flag | input | 1 | Thermal prewarning |
| openload_flag | input | 6 | Per-switch open-load comparators |
| gate_en | output | 6 | Gate enables in switch index order |
| status_word | output | 16 | Status word to the serial front end |

## Verification
The bench builds the block with UV_DLY = 4, OC_DLY = 3 and DEAD_CYC = 2. With these values, both fault filters expire in a handful of cycles, so the bench can cover three cases: a pulse shorter than the filter, a held fault, and recovery with and without a clear. With a two-cycle dead time, the exact edge on which the opposite gate rises can be counted. It can then be told apart from a same-side PWM restart, which must not wait.

// File: rtl/hb_pkg.sv
// Package: shared widths, field positions and the control-word layout
// for the half-bridge drive controller. Assumes three bridges, six switches.
package hb_pkg;
    localparam int NUM_BRIDGE = 3;
    localparam int NUM_SW     = 2 * NUM_BRIDGE;
    localparam int WORD_W     = 16;

    localparam logic [WORD_W-1:0] CFG_RESET = 16'hE000;

    // Status word field positions (decoded by the serial front end)
    localparam int ST_WARN   = 0;
    localparam int ST_SW_LSB = 1;
    localparam int ST_OVL    = 13;
    localparam int ST_INH    = 14;
    localparam int ST_PSF    = 15;

    // Control word, most significant field first
    typedef struct packed {
        logic              run;      // 15: high = active, low = standby
        logic              oc_en;    // 14: overcurrent shutdown enable
        logic              ol_off;   // 13: high = open-load reporting off
        logic [NUM_SW-1:0] pwm_sel;  // 12..7
        logic [NUM_SW-1:0] sw_en;    // 6..1
        logic              clr;      // 0: status clear request
    } hb_cfg_t;
endpackage

// File: rtl/hb_delay_filter.sv
// Module: qualifies a fault flag. The output is high once the flag has been
// high for DLY consecutive clock edges; any low cycle restarts the count.
// Assumes DLY >= 1 and a flag already synchronous to clk.
module hb_delay_filter #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_in,
    output logic qualified
);
    localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    logic [CW-1:0] cnt_q;

    // Count consecutive high cycles, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!flag_in)   cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign qualified = (cnt_q == LIMIT);
endmodule

// File: rtl/hb_fault_ctrl.sv
// Module: sticky fault state. Holds the supply-fail and overload bits, the
// per-switch overcurrent latches and the per-switch thermal latches, and
// produces the per-switch block mask. A clear pulse releases latches whose
// cause is gone; a cause present in the same cycle wins.
module hb_fault_ctrl
    import hb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              oc_en,
    input  logic              uv_valid,
    input  logic [NUM_SW-1:0] oc_valid,
    input  logic [NUM_SW-1:0] ot_flag,
    output logic              psf,
    output logic              ovl,
    output logic [NUM_SW-1:0] sw_block
);
    logic [NUM_SW-1:0] oc_hit;
    logic [NUM_SW-1:0] oc_lat_q;
    logic [NUM_SW-1:0] ot_lat_q;
    logic              psf_q;
    logic              ovl_q;

    // Overcurrent counts only while shutdown is enabled
    always_comb oc_hit = oc_valid & {NUM_SW{oc_en}};

    // Per-switch latches: set by their cause, released by clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_lat_q <= '0;
            ot_lat_q <= '0;
        end else begin
            oc_lat_q <= oc_hit  | (oc_lat_q & ~{NUM_SW{clr}});
            ot_lat_q <= ot_flag | (ot_lat_q & ~{NUM_SW{clr}});
        end
    end

    // Sticky summary bits for the status word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psf_q <= 1'b0;
            ovl_q <= 1'b0;
        end else begin
            psf_q <= uv_valid | (psf_q & ~clr);
            ovl_q <= (|oc_hit) | (|ot_flag) | (ovl_q & ~clr);
        end
    end

    assign psf      = psf_q;
    assign ovl      = ovl_q;
    assign sw_block = oc_lat_q | ot_lat_q | ot_flag;
endmodule

// File: rtl/hb_deadtime.sv
// Module: one half-bridge gate stage. Registers the two gate enables, never
// lets both be high, and delays the turn-on of one side until DEAD_CYC+1
// edges after the other side dropped. A same-side restart is not delayed.
// Assumes DEAD_CYC >= 1.
module hb_deadtime #(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_lo,
    input  logic want_hi,
    output logic gate_lo,
    output logic gate_hi
);
    localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(DEAD_CYC);

    logic [CW-1:0] idle_q;
    logic          lo_q, hi_q;
    logic          last_lo_q, last_hi_q;
    logic          lo_ok, hi_ok;

    // Turn-on permission: opposite side off and either idle long enough or same side
    always_comb begin
        lo_ok = !hi_q && ((idle_q == FULL) || last_lo_q);
        hi_ok = !lo_q && ((idle_q == FULL) || last_hi_q);
    end

    // Gate registers; high side has priority if both were ever requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end else begin
            hi_q <= want_hi && hi_ok;
            lo_q <= want_lo && !want_hi && lo_ok;
        end
    end

    // Idle counter and memory of which side conducted last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q    <= FULL;
            last_lo_q <= 1'b0;
            last_hi_q <= 1'b0;
        end else begin
            if (lo_q || hi_q)       idle_q <= '0;
            else if (idle_q != FULL) idle_q <= idle_q + 1'b1;
            if (hi_q) begin
                last_hi_q <= 1'b1;
                last_lo_q <= 1'b0;
            end else if (lo_q) begin
                last_hi_q <= 1'b0;
                last_lo_q <= 1'b1;
            end
        end
    end

    assign gate_lo = lo_q;
    assign gate_hi = hi_q;
endmodule

// File: rtl/hb_drive_ctrl.sv
// Module: top of the half-bridge drive controller. Captures the control
// word, qualifies faults, gates enables with PWM, standby and fault state,
// hands each bridge to a dead-time stage and builds the status word.
// Assumes all inputs are synchronous to clk.
module hb_drive_ctrl
    import hb_pkg::*;
#(
    parameter int UV_DLY   = 16,
    parameter int OC_DLY   = 8,
    parameter int DEAD_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] ctrl_word,
    input  logic        ctrl_commit,
    input  logic        pwm_in,
    input  logic        uv_flag,
    input  logic [5:0]  oc_flag,
    input  logic [5:0]  ot_flag,
    input  logic        prewarn_flag,
    input  logic [5:0]  openload_flag,
    output logic [5:0]  gate_en,
    output logic [15:0] status_word
);
    hb_cfg_t             cfg_q;
    logic                clr_pulse;
    logic                uv_valid;
    logic [NUM_SW-1:0]   oc_valid;
    logic                psf, ovl;
    logic [NUM_SW-1:0]   sw_block;
    logic [NUM_BRIDGE-1:0] conflict;
    logic [NUM_SW-1:0]   want;
    logic [NUM_SW-1:0]   gate;
    logic [NUM_SW-1:0]   sw_stat;

    // Control word register, loaded on commit
    always_ff @(posedge clk) begin
        if (!rst_n)           cfg_q <= hb_cfg_t'(CFG_RESET);
        else if (ctrl_commit) cfg_q <= hb_cfg_t'(ctrl_word);
    end

    // Clear request acts in the commit cycle
    always_comb clr_pulse = ctrl_commit && ctrl_word[0];

    hb_delay_filter #(.DLY(UV_DLY)) u_uv_filt (
        .clk(clk), .rst_n(rst_n), .flag_in(uv_flag), .qualified(uv_valid)
    );

    generate
        for (genvar s = 0; s < NUM_SW; s++) begin : g_oc
            hb_delay_filter #(.DLY(OC_DLY)) u_oc_filt (
                .clk(clk), .rst_n(rst_n), .flag_in(oc_flag[s]), .qualified(oc_valid[s])
            );
        end
    endgenerate

    hb_fault_ctrl u_fault (
        .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .oc_en(cfg_q.oc_en),
        .uv_valid(uv_valid), .oc_valid(oc_valid), .ot_flag(ot_flag),
        .psf(psf), .ovl(ovl), .sw_block(sw_block)
    );

    // Per-switch request: enable, PWM gate, run, supply, faults, pair conflict
    always_comb begin
        for (int b = 0; b < NUM_BRIDGE; b++)
            conflict[b] = cfg_q.sw_en[2*b] && cfg_q.sw_en[2*b+1];
        for (int s = 0; s < NUM_SW; s++)
            want[s] = cfg_q.sw_en[s] && (!cfg_q.pwm_sel[s] || pwm_in) &&
                      cfg_q.run && !uv_valid && !sw_block[s] && !conflict[s/2];
    end

    generate
        for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_bridge
            hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
                .clk(clk), .rst_n(rst_n),
                .want_lo(want[2*b]), .want_hi(want[2*b+1]),
                .gate_lo(gate[2*b]), .gate_hi(gate[2*b+1])
            );
        end
    endgenerate

    // Switch status: open-load report for idle switches when enabled
    always_comb sw_stat = gate | (openload_flag & ~gate & {NUM_SW{!cfg_q.ol_off}});

    // Status word assembly
    always_comb begin
        status_word                               = '0;
        status_word[ST_WARN]                      = prewarn_flag;
        status_word[ST_SW_LSB +: NUM_SW]          = sw_stat;
        status_word[ST_OVL]                       = ovl;
        status_word[ST_INH]                       = !cfg_q.run;
        status_word[ST_PSF]                       = psf;
    end

    assign gate_en = gate;
endmodule

// File: rtl/hb_drive_ctrl_chk.sv
// Module: assertion checker for hb_drive_ctrl, attached by bind below.
// Tracks per-bridge idle time independently of the gate stages.
module hb_drive_ctrl_chk #(
    parameter int DEAD_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  gate_en,
    input logic [15:0] status_word,
    input logic [15:0] ctrl_word,
    input logic        ctrl_commit,
    input logic        pwm_in,
    input logic        uv_valid,
    input logic [5:0]  sel_q
);
    localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(DEAD_CYC);

    generate
        for (genvar p = 0; p < 3; p++) begin : g_pair
            logic [CW-1:0] idle_cnt;
            logic          lo_last;
            logic          hi_last;

            // Observed idle time and last conducting side of this pair
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idle_cnt <= FULL;
                    lo_last  <= 1'b0;
                    hi_last  <= 1'b0;
                end else begin
                    if (gate_en[2*p] || gate_en[2*p+1]) idle_cnt <= '0;
                    else if (idle_cnt != FULL)          idle_cnt <= idle_cnt + 1'b1;
                    if (gate_en[2*p])   begin lo_last <= 1'b1; hi_last <= 1'b0; end
                    if (gate_en[2*p+1]) begin hi_last <= 1'b1; lo_last <= 1'b0; end
                end
            end

            assert_pair_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !(gate_en[2*p] && gate_en[2*p+1]));

            assert_deadtime_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gate_en[2*p+1]) && $past(lo_last) |-> $past(idle_cnt) >= FULL);

            assert_deadtime_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gate_en[2*p]) && $past(hi_last) |-> $past(idle_cnt) >= FULL);
        end

        for (genvar s = 0; s < 6; s++) begin : g_sw
            assert_pwm_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
                gate_en[s] && $past(sel_q[s]) |-> $past(pwm_in));
        end
    endgenerate

    assert_standby_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[14] && $past(status_word[14]) |-> gate_en == 6'b0);

    assert_uv_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_valid) |-> gate_en == 6'b0);

    assert_psf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[15] && !(ctrl_commit && ctrl_word[0]) |=> status_word[15]);

    assert_ovl_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[13] && !(ctrl_commit && ctrl_word[0]) |=> status_word[13]);
endmodule

bind hb_drive_ctrl hb_drive_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .status_word(status_word),
    .ctrl_word(ctrl_word), .ctrl_commit(ctrl_commit), .pwm_in(pwm_in),
    .uv_valid(uv_valid), .sel_q(cfg_q.pwm_sel)
);

// File: tb/tb_hb_drive_ctrl.sv
// Bench: table-driven steady-state checks, then directed fault, timing and reset tests.
module tb_hb_drive_ctrl;
    localparam int DEAD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = 16'h0;
    logic        ctrl_commit = 1'b0;
    logic        pwm_in = 1'b0;
    logic        uv_flag = 1'b0;
    logic [5:0]  oc_flag = 6'h0;
    logic [5:0]  ot_flag = 6'h0;
    logic        prewarn_flag = 1'b0;
    logic [5:0]  openload_flag = 6'h0;
    logic [5:0]  gate_en;
    logic [15:0] status_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hb_drive_ctrl #(.UV_DLY(4), .OC_DLY(3), .DEAD_CYC(DEAD)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ctrl_commit(ctrl_commit),
        .pwm_in(pwm_in), .uv_flag(uv_flag), .oc_flag(oc_flag), .ot_flag(ot_flag),
        .prewarn_flag(prewarn_flag), .openload_flag(openload_flag),
        .gate_en(gate_en), .status_word(status_word)
    );

    // Vector: {ctrl, pwm, oc, prewarn, openload, exp_gate, exp_status, req}
    localparam int NV = 11;
    localparam logic [55:0] VEC [NV] = '{
        {16'hE002, 1'b0, 6'h00, 1'b0, 6'h00, 6'h01, 16'h0002, 4'd1},  // R1 low side 1
        {16'hE00C, 1'b0, 6'h00, 1'b0, 6'h00, 6'h06, 16'h000C, 4'd1},  // R1 two switches
        {16'hE046, 1'b0, 6'h00, 1'b0, 6'h00, 6'h20, 16'h0040, 4'd2},  // R2 pair 1 conflict
        {16'hE410, 1'b0, 6'h00, 1'b0, 6'h00, 6'h00, 16'h0000, 4'd1},  // R1 PWM low
        {16'hE410, 1'b1, 6'h00, 1'b0, 6'h00, 6'h08, 16'h0010, 4'd1},  // R1 PWM high
        {16'hE400, 1'b1, 6'h00, 1'b0, 6'h00, 6'h00, 16'h0000, 4'd1},  // R1 PWM alone
        {16'h6002, 1'b0, 6'h00, 1'b0, 6'h00, 6'h00, 16'h4000, 4'd4},  // R4 standby
        {16'hC002, 1'b0, 6'h00, 1'b1, 6'h3F, 6'h01, 16'h007F, 4'd9},  // R9 R10 open load
        {16'hC003, 1'b0, 6'h00, 1'b0, 6'h2A, 6'h01, 16'h0056, 4'd9},  // R9 clear no effect
        {16'hA002, 1'b0, 6'h3F, 1'b0, 6'h00, 6'h01, 16'h0002, 4'd6},  // R6 shutdown off
        {16'hE002, 1'b0, 6'h00, 1'b0, 6'h00, 6'h01, 16'h0002, 4'd6}   // R6 nothing latched
    };

    task automatic check(input logic [5:0] eg, input logic [15:0] es, input string req);
        n_chk++;
        if (gate_en !== eg || status_word !== es) begin
            n_fail++;
            $display("FAIL %s gate=%h exp %h status=%h exp %h", req, gate_en, eg, status_word, es);
        end
    endtask

    task automatic write(input logic [15:0] w);
        @(negedge clk);
        ctrl_word = w;
        ctrl_commit = 1'b1;
        @(negedge clk);
        ctrl_commit = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(6'h00, 16'h0000, "R11 reset");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pwm_in        = VEC[v][39];
            oc_flag       = VEC[v][38:33];
            prewarn_flag  = VEC[v][32];
            openload_flag = VEC[v][31:26];
            write(VEC[v][55:40]);
            repeat (12) @(negedge clk);
            check(VEC[v][25:20], VEC[v][19:4], $sformatf("R%0d vec%0d", VEC[v][3:0], v));
        end
        oc_flag = 6'h0; openload_flag = 6'h0; prewarn_flag = 1'b0; pwm_in = 1'b0;

        // R5 undervoltage: short pulse, long fault, recovery, clear
        write(16'hE002);
        repeat (6) @(negedge clk);
        uv_flag = 1'b1;
        repeat (2) @(negedge clk);
        uv_flag = 1'b0;
        repeat (4) @(negedge clk);
        check(6'h01, 16'h0002, "R5 short pulse");
        uv_flag = 1'b1;
        repeat (8) @(negedge clk);
        check(6'h00, 16'h8000, "R5 held fault");
        uv_flag = 1'b0;
        repeat (4) @(negedge clk);
        check(6'h01, 16'h8002, "R5 auto recovery");
        write(16'hE003);
        repeat (4) @(negedge clk);
        check(6'h01, 16'h0002, "R8 clear supply fail");

        // R6 overcurrent latch on switch 0
        write(16'hE00A);
        repeat (8) @(negedge clk);
        oc_flag = 6'h01;
        repeat (8) @(negedge clk);
        check(6'h04, 16'h2008, "R6 trip");
        oc_flag = 6'h00;
        repeat (4) @(negedge clk);
        check(6'h04, 16'h2008, "R6 latched");
        write(16'hE00B);
        repeat (6) @(negedge clk);
        check(6'h05, 16'h000A, "R8 clear overcurrent");

        // R7 overtemperature on switch 2
        ot_flag = 6'h04;
        repeat (4) @(negedge clk);
        check(6'h01, 16'h2002, "R7 shutdown");
        write(16'hE00B);
        repeat (4) @(negedge clk);
        check(6'h01, 16'h2002, "R7 clear while hot");
        ot_flag = 6'h00;
        repeat (4) @(negedge clk);
        check(6'h01, 16'h2002, "R7 cooled no clear");
        write(16'hE00B);
        repeat (6) @(negedge clk);
        check(6'h05, 16'h000A, "R7 cooled and cleared");

        // R3 dead time: low side 1 to high side 1
        write(16'hE002);
        repeat (8) @(negedge clk);
        begin
            int k_fall = -1;
            int k_rise = -1;
            write(16'hE004);
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                if (k_fall < 0 && !gate_en[0]) k_fall = k;
                if (k_rise < 0 && gate_en[1])  k_rise = k;
            end
            n_chk++;
            if (k_fall != 1) begin
                n_fail++;
                $display("FAIL R3 fall edge %0d exp %0d", k_fall, 1);
            end
            n_chk++;
            if (k_rise - k_fall != DEAD + 1) begin
                n_fail++;
                $display("FAIL R3 gap %0d exp %0d", k_rise - k_fall, DEAD + 1);
            end
        end

        // R1 / R3 PWM follows with one cycle latency, same side no wait
        write(16'hE410);
        repeat (6) @(negedge clk);
        pwm_in = 1'b1;
        @(negedge clk);
        check(6'h08, 16'h0010, "R1 pwm rise");
        pwm_in = 1'b0;
        @(negedge clk);
        check(6'h00, 16'h0000, "R1 pwm fall");
        pwm_in = 1'b1;
        @(negedge clk);
        check(6'h08, 16'h0010, "R3 same side restart");

        // R11 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pwm_in = 1'b0;
        @(negedge clk);
        check(6'h00, 16'h0000, "R11 reset again");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule